// File: doc/BRIEF.md
# Scan chain integrity tester

This block is a test-access master that confirms a serial chain of boundary-scan devices is wired up and responding. One start pulse makes it generate a test clock, a mode-select stream and a data stream from the system clock. First the mode-select stream forces every device in the chain into its logic-reset state. It then walks the devices through the idle state and the instruction capture state and into instruction shifting. While that happens the data stream is held high.

While shifting, the block samples the serial return line from the last device on each rising test-clock edge. It compares the stream bit by bit with what a healthy chain must return. Each device first gives back its captured instruction word, least significant bit first, starting with the device nearest the return line. After that come the ones that entered the chain at its input. When the run ends, the block raises either pass or fail. On a fail it reports the position of the first wrong bit. It then parks the chain back in logic-reset and drops busy.

The device count, instruction length, expected capture word, number of trailing ones and test-clock divider are all parameters. Chains of different shapes are tested by changing the parameters, not the logic.

Top module: `scan_integrity_tester`

## Requirements
- R1: After reset, `busy_o`, `pass_o` and `fail_o` are 0, `tck_o` is 0 and `tms_o` is 1.
- R2: A run starts with five test-clock pulses carrying mode-select 1, followed by one pulse carrying 0.
- R3: Pulses 7 and 8 carry mode-select 1 and pulses 9 and 10 carry 0, which leaves every device in instruction shifting.
- R4: `tdi_o` is 1 at every test-clock rising edge of a run.
- R5: `tms_o` only changes while `tck_o` is low, and `tck_o` stays low whenever the block is idle.
- R6: The shift window is pulses 11 to 10+K, where K = NUM_DEV*IR_LEN + TRAIL_ONES. Mode-select is 0 on all of these pulses except the last, which carries 1. The return line is sampled at every rising edge in the window. For bit index i (0 = first sampled), the expected value is bit (i mod IR_LEN) of IR_CAPTURE (default 8'h01) when i < NUM_DEV*IR_LEN, and 1 otherwise.
- R7: At the end of a run, exactly one of `pass_o` and `fail_o` is 1. `fail_o` is raised when at least one sampled bit differs from its expected value. In that case `err_idx_o` holds the index of the first differing bit. Both verdict flags are cleared when a run starts and are held unchanged while the block is idle.
- R8: After the shift window there are five pulses carrying mode-select 1, which returns every device to logic-reset. `busy_o` falls on the falling edge of the last pulse. A run therefore has 15+K pulses in total.
- R9: A start pulse that arrives while `busy_o` is 1 has no effect: the run still has exactly 15+K pulses.
- R10: Each test-clock level lasts CLK_HALF system clock cycles, so `busy_o` stays high for 2*CLK_HALF*(15+K) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| tdo_i | input | 1 | Serial return from the last device in the chain |
| tck_o | output | 1 | Generated test clock |
| tms_o | output | 1 | Mode-select driven to every device |
| tdi_o | output | 1 | Serial data into the first device |
| busy_o | output | 1 | A run is in progress |
| pass_o | output | 1 | Last run returned the expected stream |
| fail_o | output | 1 | Last run saw at least one wrong bit |
| err_idx_o | output | IDX_W | Index of the first wrong bit of the last failed run |

## Verification
The bench builds the tester with NUM_DEV = 3 and CLK_HALF = 3, and connects it to three behavioural devices that each run the full sixteen-state controller. With three devices, an injected fault can land in the first, middle or last instruction word, so the reported index shows whether the chain order is decoded correctly. An odd half-period uses the counter variant of the divider and makes the busy-time count depend on the exact divider period. Return lines stuck at 0 and stuck at 1 put the first mismatch at indices 0 and 1.

// File: rtl/sit_pkg.sv
package sit_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RESET,
      PH_RUNIDLE,
      PH_SELECT,
      PH_CAPTURE,
      PH_SHIFT,
      PH_PARK
   } sit_phase_e;

   localparam int RESET_PULSES  = 5;
   localparam int SELECT_PULSES = 2;
   localparam int ENTRY_PULSES  = 2;
   localparam int PARK_PULSES   = 5;
   localparam int PRE_PULSES    = RESET_PULSES + 1 + SELECT_PULSES + ENTRY_PULSES;

endpackage

// File: rtl/sit_tck_div.sv
module sit_tck_div #(
   parameter int CLK_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tck,
   output logic rise_evt,
   output logic fall_evt
);

   logic edge_due;

   generate
      if (CLK_HALF == 1) begin : g_direct
         assign edge_due = run;
      end else begin : g_count
         localparam int CW = $clog2(CLK_HALF);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run || cnt == CW'(CLK_HALF - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign edge_due = run && (cnt == CW'(CLK_HALF - 1));
      end
   endgenerate

   assign rise_evt = edge_due && !tck;
   assign fall_evt = edge_due && tck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tck <= 1'b0;
      end else if (!run) begin
         tck <= 1'b0;
      end else if (edge_due) begin
         tck <= !tck;
      end
   end

endmodule

// File: rtl/sit_tms_seq.sv
module sit_tms_seq
   import sit_pkg::*;
#(
   parameter int CHECK_BITS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rise_evt,
   input  logic fall_evt,
   output logic busy,
   output logic tms,
   output logic start_stb,
   output logic sample_stb,
   output logic done_stb
);

   localparam int TOTAL      = PRE_PULSES + CHECK_BITS + PARK_PULSES;
   localparam int SHIFT_LAST = PRE_PULSES + CHECK_BITS;
   localparam int PCW        = $clog2(TOTAL + 1);

   logic [PCW-1:0] pcnt;
   logic [PCW-1:0] pnext;
   sit_phase_e     phase;
   sit_phase_e     phase_next;

   function automatic sit_phase_e phase_of(input logic [PCW-1:0] p);
      if (p == '0)                                             return PH_IDLE;
      if (p <= PCW'(RESET_PULSES))                             return PH_RESET;
      if (p == PCW'(RESET_PULSES + 1))                         return PH_RUNIDLE;
      if (p <= PCW'(RESET_PULSES + 1 + SELECT_PULSES))         return PH_SELECT;
      if (p <= PCW'(PRE_PULSES))                               return PH_CAPTURE;
      if (p <= PCW'(SHIFT_LAST))                               return PH_SHIFT;
      return PH_PARK;
   endfunction

   function automatic logic tms_of(input sit_phase_e ph, input logic [PCW-1:0] p);
      case (ph)
         PH_RUNIDLE, PH_CAPTURE: return 1'b0;
         PH_SHIFT:               return (p == PCW'(SHIFT_LAST));
         default:                return 1'b1;
      endcase
   endfunction

   assign pnext      = pcnt + 1'b1;
   assign phase      = phase_of(pcnt);
   assign phase_next = phase_of(pnext);

   assign start_stb  = start && !busy;
   assign sample_stb = busy && rise_evt && (phase == PH_SHIFT);
   assign done_stb   = busy && fall_evt && (pcnt == PCW'(TOTAL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         pcnt <= '0;
         tms  <= 1'b1;
      end else if (start_stb) begin
         busy <= 1'b1;
         pcnt <= PCW'(1);
         tms  <= 1'b1;
      end else if (busy && fall_evt) begin
         if (pcnt == PCW'(TOTAL)) begin
            busy <= 1'b0;
            pcnt <= '0;
            tms  <= 1'b1;
         end else begin
            pcnt <= pnext;
            tms  <= tms_of(phase_next, pnext);
         end
      end
   end

endmodule

// File: rtl/sit_tdo_cmp.sv
module sit_tdo_cmp #(
   parameter int                 NUM_DEV    = 3,
   parameter int                 IR_LEN     = 8,
   parameter logic [IR_LEN-1:0]  IR_CAPTURE = 1,
   parameter int                 IDX_W      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_stb,
   input  logic             sample_stb,
   input  logic             done_stb,
   input  logic             tdo,
   output logic             pass,
   output logic             fail,
   output logic [IDX_W-1:0] err_idx
);

   localparam int CAP_BITS = NUM_DEV * IR_LEN;
   localparam int BPW      = (IR_LEN > 1) ? $clog2(IR_LEN) : 1;

   logic [IDX_W-1:0] idx;
   logic [BPW-1:0]   bpos;
   logic             seen_bad;
   logic             exp_bit;

   assign exp_bit = (idx < IDX_W'(CAP_BITS)) ? IR_CAPTURE[bpos] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx      <= '0;
         bpos     <= '0;
         seen_bad <= 1'b0;
         err_idx  <= '0;
         pass     <= 1'b0;
         fail     <= 1'b0;
      end else if (start_stb) begin
         idx      <= '0;
         bpos     <= '0;
         seen_bad <= 1'b0;
         err_idx  <= '0;
         pass     <= 1'b0;
         fail     <= 1'b0;
      end else begin
         if (sample_stb) begin
            if (tdo != exp_bit && !seen_bad) begin
               seen_bad <= 1'b1;
               err_idx  <= idx;
            end
            idx  <= idx + 1'b1;
            bpos <= (bpos == BPW'(IR_LEN - 1)) ? '0 : bpos + 1'b1;
         end
         if (done_stb) begin
            pass <= !seen_bad;
            fail <= seen_bad;
         end
      end
   end

endmodule

// File: rtl/scan_integrity_tester.sv
module scan_integrity_tester #(
   parameter int                NUM_DEV    = 3,
   parameter int                IR_LEN     = 8,
   parameter logic [IR_LEN-1:0] IR_CAPTURE = 1,
   parameter int                TRAIL_ONES = 8,
   parameter int                CLK_HALF   = 2,
   localparam int               CHECK_BITS = NUM_DEV * IR_LEN + TRAIL_ONES,
   localparam int               IDX_W      = $clog2(CHECK_BITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tdo_i,
   output logic             tck_o,
   output logic             tms_o,
   output logic             tdi_o,
   output logic             busy_o,
   output logic             pass_o,
   output logic             fail_o,
   output logic [IDX_W-1:0] err_idx_o
);

   generate
      if (NUM_DEV < 1) begin : g_bad_dev
         $error("NUM_DEV must be at least 1");
      end
      if (IR_LEN < 2) begin : g_bad_len
         $error("IR_LEN must be at least 2");
      end
      if (IR_CAPTURE[1:0] != 2'b01) begin : g_bad_cap
         $error("IR_CAPTURE must end in binary 01");
      end
      if (TRAIL_ONES < 1) begin : g_bad_trail
         $error("TRAIL_ONES must be at least 1");
      end
      if (CLK_HALF < 1) begin : g_bad_half
         $error("CLK_HALF must be at least 1");
      end
   endgenerate

   logic rise_evt;
   logic fall_evt;
   logic start_stb;
   logic sample_stb;
   logic done_stb;

   assign tdi_o = 1'b1;

   sit_tck_div #(
      .CLK_HALF (CLK_HALF)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy_o),
      .tck      (tck_o),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   sit_tms_seq #(
      .CHECK_BITS (CHECK_BITS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .rise_evt   (rise_evt),
      .fall_evt   (fall_evt),
      .busy       (busy_o),
      .tms        (tms_o),
      .start_stb  (start_stb),
      .sample_stb (sample_stb),
      .done_stb   (done_stb)
   );

   sit_tdo_cmp #(
      .NUM_DEV    (NUM_DEV),
      .IR_LEN     (IR_LEN),
      .IR_CAPTURE (IR_CAPTURE),
      .IDX_W      (IDX_W)
   ) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_stb  (start_stb),
      .sample_stb (sample_stb),
      .done_stb   (done_stb),
      .tdo        (tdo_i),
      .pass       (pass_o),
      .fail       (fail_o),
      .err_idx    (err_idx_o)
   );

endmodule

// File: rtl/sit_chk.sv
module sit_chk (
   input logic clk,
   input logic rst_n,
   input logic tck_o,
   input logic tms_o,
   input logic tdi_o,
   input logic busy_o,
   input logic pass_o,
   input logic fail_o
);

   // R5
   tck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !tck_o);

   // R5
   tms_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tck_o && $past(tck_o)) |-> $stable(tms_o));

   // R1
   tms_idle_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> tms_o);

   // R4
   tdi_held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> tdi_o);

   // R7
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o));

   // R8
   done_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (pass_o ^ fail_o));

   // R7
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (!pass_o && !fail_o));

   // R7
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> ($stable(pass_o) && $stable(fail_o)));

endmodule

bind scan_integrity_tester sit_chk u_sit_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tck_o  (tck_o),
   .tms_o  (tms_o),
   .tdi_o  (tdi_o),
   .busy_o (busy_o),
   .pass_o (pass_o),
   .fail_o (fail_o)
);

// File: tb/scan_integrity_tester_bench.sv
module scan_integrity_tester_bench;

   localparam int NUM_DEV  = 3;
   localparam int CLK_HALF = 3;
   localparam int CAP      = NUM_DEV * 8;
   localparam int K        = CAP + 8;
   localparam int TOTAL    = 15 + K;
   localparam int IDX_W    = $clog2(K + 1);

   typedef enum int {
      T_RESET, T_IDLE, T_SDR, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
      T_SIR, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR
   } tap_e;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             tdo_w;
   logic             tck_w, tms_w, tdi_w, busy_w, pass_w, fail_w;
   logic [IDX_W-1:0] err_w;

   int   n_checks = 0;
   int   n_fail   = 0;
   int   cyc      = 0;

   logic [7:0] mask [NUM_DEV] = '{default: 8'h00};
   tap_e       st   [NUM_DEV] = '{default: T_PDR};
   logic [7:0] ir   [NUM_DEV] = '{default: 8'h00};
   logic       dtdo [NUM_DEV] = '{default: 1'b0};
   int         stuck_mode = 0;

   int pc = 0;
   int pc_base = 0;
   int bad_r2 = 0, bad_r3 = 0, bad_r4 = 0, bad_r6 = 0, bad_r8 = 0;
   int busy_cyc = 0;

   always #4 clk = !clk;

   scan_integrity_tester #(
      .NUM_DEV  (NUM_DEV),
      .CLK_HALF (CLK_HALF)
   ) u_scan_integrity_tester (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tdo_i     (tdo_w),
      .tck_o     (tck_w),
      .tms_o     (tms_w),
      .tdi_o     (tdi_w),
      .busy_o    (busy_w),
      .pass_o    (pass_w),
      .fail_o    (fail_w),
      .err_idx_o (err_w)
   );

   assign tdo_w = (stuck_mode == 1) ? 1'b0 :
                  (stuck_mode == 2) ? 1'b1 : dtdo[NUM_DEV-1];

   function automatic tap_e tap_next(input tap_e s, input logic m);
      case (s)
         T_RESET: return m ? T_RESET : T_IDLE;
         T_IDLE:  return m ? T_SDR   : T_IDLE;
         T_SDR:   return m ? T_SIR   : T_CDR;
         T_CDR:   return m ? T_E1DR  : T_SHDR;
         T_SHDR:  return m ? T_E1DR  : T_SHDR;
         T_E1DR:  return m ? T_UDR   : T_PDR;
         T_PDR:   return m ? T_E2DR  : T_PDR;
         T_E2DR:  return m ? T_UDR   : T_SHDR;
         T_UDR:   return m ? T_SDR   : T_IDLE;
         T_SIR:   return m ? T_RESET : T_CIR;
         T_CIR:   return m ? T_E1IR  : T_SHIR;
         T_SHIR:  return m ? T_E1IR  : T_SHIR;
         T_E1IR:  return m ? T_UIR   : T_PIR;
         T_PIR:   return m ? T_E2IR  : T_PIR;
         T_E2IR:  return m ? T_UIR   : T_SHIR;
         default: return m ? T_SDR   : T_IDLE;
      endcase
   endfunction

   // expected mode-select per pulse number (1-based), from R2, R3, R6, R8
   function automatic logic tms_exp(input int p);
      if (p <= 5)      return 1'b1;
      if (p == 6)      return 1'b0;
      if (p <= 8)      return 1'b1;
      if (p <= 10)     return 1'b0;
      if (p < 10 + K)  return 1'b0;
      return 1'b1;
   endfunction

   // first index where the returned stream differs from R6, or -1
   function automatic int first_bad(input int smode);
      for (int i = 0; i < K; i++) begin
         logic       e, a;
         logic [7:0] w;
         e = (i < CAP) ? (i % 8 == 0) : 1'b1;
         if (smode == 1)      a = 1'b0;
         else if (smode == 2) a = 1'b1;
         else if (i < CAP) begin
            w = 8'h01 ^ mask[NUM_DEV - 1 - i / 8];
            a = w[i % 8];
         end else a = 1'b1;
         if (a != e) return i;
      end
      return -1;
   endfunction

   // chain of devices plus pulse log
   always @(posedge tck_w) begin
      int p;
      pc = pc + 1;
      p  = pc - pc_base;
      if (!tdi_w) bad_r4 = bad_r4 + 1;
      if (p <= 6)                  begin if (tms_w != tms_exp(p)) bad_r2 = bad_r2 + 1; end
      else if (p <= 10)            begin if (tms_w != tms_exp(p)) bad_r3 = bad_r3 + 1; end
      else if (p <= 10 + K)        begin if (tms_w != tms_exp(p)) bad_r6 = bad_r6 + 1; end
      else if (p <= TOTAL)         begin if (tms_w != tms_exp(p)) bad_r8 = bad_r8 + 1; end
      else bad_r8 = bad_r8 + 1;
      for (int d = 0; d < NUM_DEV; d++) begin
         logic din;
         din = (d == 0) ? tdi_w : dtdo[d-1];
         if (st[d] == T_CIR)       ir[d] <= 8'h01 ^ mask[d];
         else if (st[d] == T_SHIR) ir[d] <= {din, ir[d][7:1]};
         st[d] <= tap_next(st[d], tms_w);
      end
   end

   always @(negedge tck_w) begin
      for (int d = 0; d < NUM_DEV; d++)
         if (st[d] == T_SHIR) dtdo[d] <= ir[d][0];
   end

   always @(negedge clk) if (busy_w) busy_cyc = busy_cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic run_one(input int smode, input bit double_start);
      int b2, b3, b4, b6, b8, bc, to, expect_bad, all_reset;
      stuck_mode = smode;
      b2 = bad_r2; b3 = bad_r3; b4 = bad_r4; b6 = bad_r6; b8 = bad_r8;
      pc_base = pc;
      bc = busy_cyc;
      expect_bad = first_bad(smode);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      to = 0;
      while (busy_w && to < 5000) begin
         @(negedge clk);
         to++;
         if (double_start && (to == 40 || to == 200)) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      @(negedge clk);
      chk(bad_r2 == b2, "R2 reset/idle mode-select", bad_r2 - b2, 0);
      chk(bad_r3 == b3, "R3 select/capture mode-select", bad_r3 - b3, 0);
      chk(bad_r4 == b4, "R4 data held high", bad_r4 - b4, 0);
      chk(bad_r6 == b6, "R6 shift-window mode-select", bad_r6 - b6, 0);
      chk(bad_r8 == b8 && pc - pc_base == TOTAL, "R8 park pulses and count",
          pc - pc_base, TOTAL);
      all_reset = 1;
      for (int d = 0; d < NUM_DEV; d++) if (st[d] != T_RESET) all_reset = 0;
      chk(all_reset == 1, "R8 chain parked in logic-reset", all_reset, 1);
      chk(busy_cyc - bc == 2 * CLK_HALF * TOTAL, "R10 busy duration",
          busy_cyc - bc, 2 * CLK_HALF * TOTAL);
      chk(fail_w == (expect_bad >= 0) && pass_w == (expect_bad < 0),
          "R7 verdict (fail flag)", int'(fail_w), int'(expect_bad >= 0));
      if (expect_bad >= 0)
         chk(int'(err_w) == expect_bad, "R7 first error index", int'(err_w), expect_bad);
      if (double_start)
         chk(pc - pc_base == TOTAL, "R9 start ignored while busy", pc - pc_base, TOTAL);
      repeat (5) @(negedge clk);
      chk(pass_w == (expect_bad < 0) && !tck_w, "R7 verdict held while idle",
          int'(pass_w), int'(expect_bad < 0));
   endtask

   initial begin
      void'($urandom(32'd1149));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_w && !pass_w && !fail_w && !tck_w && tms_w, "R1 reset state",
          {busy_w, pass_w, fail_w, tck_w, tms_w}, 5'b00001);

      // directed: healthy chain
      run_one(0, 1'b0);
      // R6: device nearest the return line shifts first
      mask[NUM_DEV-1] = 8'h01;
      run_one(0, 1'b0);
      mask[NUM_DEV-1] = 8'h00;
      // R6: device at the chain input is last; its top bit is index CAP-1
      mask[0] = 8'h80;
      run_one(0, 1'b0);
      mask[0] = 8'h00;
      // stuck return line
      run_one(1, 1'b0);
      run_one(2, 1'b0);
      // R9: restart attempts during the run
      mask[1] = 8'h04;
      run_one(0, 1'b1);
      mask[1] = 8'h00;
      run_one(0, 1'b1);

      // random fault patterns
      for (int r = 0; r < 12; r++) begin
         for (int d = 0; d < NUM_DEV; d++)
            mask[d] = ($urandom % 3 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
         run_one(0, ($urandom % 4) == 0);
      end

      finish_run();
   end

endmodule